// File: doc/BRIEF.md
# Cascaded Serial DAC Loader

This block is the host side of a chain of 12-bit serial DACs that are wired in cascade, each device's serial output feeding the next device's serial input. It collects one 12-bit word per device through a valid/ready handshake. It then runs one transfer. The frame select goes low and exactly sixteen serial clock pulses per device are sent. The select then goes high, and a shared load strobe pulses low so that every device updates its output in the same instant.

Each device receives a 16-bit frame: four padding bits, sent as zeros, then the 12-bit word MSB first. The frame for the device farthest from the host goes out first. Each frame travels down the chain, so after the burst every device holds its own word. The serial clock idles high. The serial data changes on a rising serial clock edge, and the devices sample on the falling edge. The number of devices, the serial clock half period (in system clocks) and the width of the load pulse are parameters.

Top module: `dac_chain_loader`

## Requirements
- R1: While and after reset, with no words offered: frameSyncN, loadN and serClk are 1, busy is 0 and inReady is 1.
- R2: A word is taken on a clock edge where inValid and inReady are both 1. inReady is 0 whenever busy is 1, and words offered while busy are not taken. Fewer than NUM_DEV taken words start no transfer.
- R3: A transfer holds frameSyncN low for exactly 16·NUM_DEV falling edges of serClk.
- R4: Each 16-bit frame begins with four padding bits of value 0, followed by the 12-bit word MSB first.
- R5: The k-th word taken (k = 0 for the first) ends up in device k, where device 0 is the one whose serial input is driven by the host. The frame for device NUM_DEV-1 is sent first.
- R6: While frameSyncN is low, serData changes only in a cycle where serClk rises. It is stable while serClk is low.
- R7: loadN is low only while frameSyncN is high. It falls after frameSyncN has returned high at the end of the burst.
- R8: Each transfer produces exactly one low pulse on loadN, lasting LOAD_LEN system clocks.
- R9: busy rises on the edge that takes the last word of a set. It stays 1 while loadN is low and falls on the edge where loadN returns high.
- R10: While frameSyncN is low, every low phase of serClk lasts HALF_DIV system clocks. serClk is 1 whenever frameSyncN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A word is offered on inData |
| inReady | output | 1 | The loader can take a word |
| inData | input | DATA_W | Word for the next device in order |
| busy | output | 1 | A transfer or load pulse is in progress |
| serClk | output | 1 | Serial clock to the chain, idles high |
| serData | output | 1 | Serial data to the first device |
| frameSyncN | output | 1 | Active-low frame select shared by the chain |
| loadN | output | 1 | Active-low shared output-update strobe |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that LOAD_LEN is at least 2, so that a pulse spans more than one sampled cycle. They make no assumption about when inValid rises or falls, because a word offered while the loader is not ready is simply left alone. The stimulus offers words with and without idle gaps, and it keeps inValid high with junk data during a burst. It resets only while the loader holds no half-finished set, except in one directed case whose purpose is to test a reset in the middle of a burst.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;    // insert a new frame at the head of the chain register
    logic shift;   // advance one bit (rising serial clock)
    logic active;  // burst in progress, serial data is live
  } dpStrobe_t;

  typedef enum logic [1:0] {
    S_LOAD  = 2'd0,
    S_SHIFT = 2'd1,
    S_GAP   = 2'd2,
    S_PULSE = 2'd3
  } seqState_t;

endpackage

// File: rtl/dac_chain_datapath.sv
module dac_chain_datapath
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  output logic              serData
);

  localparam int TOT_BITS = NUM_DEV * FRAME_W;
  localparam int PAD_W    = FRAME_W - DATA_W;

  logic [TOT_BITS-1:0] chainReg;
  logic [TOT_BITS-1:0] loadVal;
  logic [FRAME_W-1:0]  newFrame;

  // Padding bits go out as zeros ahead of the data word
  assign newFrame = {{PAD_W{1'b0}}, inData};

  // New frames enter at the head, so the last word taken is sent first
  generate
    if (NUM_DEV == 1) begin : g_single
      assign loadVal = newFrame;
    end else begin : g_multi
      assign loadVal = {newFrame, chainReg[TOT_BITS-1:FRAME_W]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainReg <= '0;
    end else if (strobe.load) begin
      chainReg <= loadVal;
    end else if (strobe.shift) begin
      chainReg <= {chainReg[TOT_BITS-2:0], 1'b0};
    end
  end

  assign serData = strobe.active & chainReg[TOT_BITS-1];

endmodule

// File: rtl/dac_chain_ctrl.sv
module dac_chain_ctrl
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2,
  parameter int LOAD_LEN = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      busy,
  output logic      serClk,
  output logic      frameSyncN,
  output logic      loadN,
  output dpStrobe_t strobe
);

  localparam int TOT_BITS = NUM_DEV * FRAME_W;
  localparam int CNT_W    = $clog2(TOT_BITS + 1);
  localparam int WORD_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PULSE_W  = (LOAD_LEN > 1) ? $clog2(LOAD_LEN) : 1;

  seqState_t          state;
  logic [WORD_W-1:0]  wordCnt;
  logic [DIV_W-1:0]   divCnt;
  logic [CNT_W-1:0]   fallCnt;
  logic [PULSE_W-1:0] pulseCnt;
  logic               sclkQ;

  logic accept, divEnd, riseNow, lastRise, lastWord, pulseEnd;

  assign inReady  = (state == S_LOAD);
  assign accept   = inValid && inReady;
  assign lastWord = (wordCnt == WORD_W'(NUM_DEV - 1));
  assign divEnd   = (divCnt == DIV_W'(HALF_DIV - 1));
  assign riseNow  = (state == S_SHIFT) && divEnd && !sclkQ;
  assign lastRise = riseNow && (fallCnt == CNT_W'(TOT_BITS));
  assign pulseEnd = (pulseCnt == PULSE_W'(LOAD_LEN - 1));

  assign strobe.load   = accept;
  assign strobe.shift  = riseNow && !lastRise;
  assign strobe.active = (state == S_SHIFT);

  assign busy       = (state != S_LOAD);
  assign frameSyncN = (state != S_SHIFT);
  assign loadN      = (state != S_PULSE);
  assign serClk     = sclkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_LOAD;
      wordCnt  <= '0;
      divCnt   <= '0;
      fallCnt  <= '0;
      pulseCnt <= '0;
      sclkQ    <= 1'b1;
    end else begin
      case (state)
        S_LOAD: begin
          if (accept) begin
            if (lastWord) begin
              wordCnt <= '0;
              divCnt  <= '0;
              fallCnt <= '0;
              sclkQ   <= 1'b1;
              state   <= S_SHIFT;
            end else begin
              wordCnt <= wordCnt + 1'b1;
            end
          end
        end
        S_SHIFT: begin
          divCnt <= divEnd ? '0 : divCnt + 1'b1;
          if (divEnd) begin
            sclkQ <= !sclkQ;
            if (sclkQ) fallCnt <= fallCnt + 1'b1;
          end
          if (lastRise) state <= S_GAP;
        end
        S_GAP: begin
          pulseCnt <= '0;
          state    <= S_PULSE;
        end
        default: begin
          if (pulseEnd) state <= S_LOAD;
          else          pulseCnt <= pulseCnt + 1'b1;
        end
      endcase
    end
  end

  // Load strobe never overlaps the frame select
  p_load_outside_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |-> frameSyncN);

  // No word is taken while a transfer is running
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !busy);

  // Serial clock parks high outside a burst
  p_clk_park_r10: assert property (@(posedge clk) disable iff (!rstN)
    frameSyncN |-> serClk);

  // busy drops together with the end of the load pulse
  p_busy_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadN) |-> !busy);

  // A load pulse lasts more than one cycle
  p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadN) |=> !loadN);

endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dac_chain_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int DATA_W   = 12,
  parameter int FRAME_W  = 16,
  parameter int HALF_DIV = 2,
  parameter int LOAD_LEN = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              busy,
  output logic              serClk,
  output logic              serData,
  output logic              frameSyncN,
  output logic              loadN
);

  localparam int TOT_BITS = NUM_DEV * FRAME_W;
  localparam int CNT_W    = $clog2(TOT_BITS + 1);

  dpStrobe_t strobe;

  dac_chain_ctrl #(
    .NUM_DEV (NUM_DEV),
    .FRAME_W (FRAME_W),
    .HALF_DIV(HALF_DIV),
    .LOAD_LEN(LOAD_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inReady   (inReady),
    .busy      (busy),
    .serClk    (serClk),
    .frameSyncN(frameSyncN),
    .loadN     (loadN),
    .strobe    (strobe)
  );

  dac_chain_datapath #(
    .NUM_DEV(NUM_DEV),
    .DATA_W (DATA_W),
    .FRAME_W(FRAME_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .inData (inData),
    .serData(serData)
  );

  // Assertion-only tally of serial clock falls inside the frame
  logic [CNT_W-1:0] fallSeen;
  logic             sclkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fallSeen <= '0;
      sclkPrev <= 1'b1;
    end else begin
      sclkPrev <= serClk;
      if (frameSyncN)               fallSeen <= '0;
      else if (sclkPrev && !serClk) fallSeen <= fallSeen + 1'b1;
    end
  end

  p_burst_length_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSyncN) |-> (fallSeen == CNT_W'(TOT_BITS)));

  p_data_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!frameSyncN && !serClk && $past(!frameSyncN && !serClk)) |-> $stable(serData));

endmodule

// File: tb/dac_chain_loader_bench.sv
module dac_chain_loader_bench;

  localparam int NDEV  = 3;
  localparam int HALF  = 2;
  localparam int PLEN  = 6;
  localparam int NVEC  = 4;
  localparam int BURST = 16 * NDEV;

  // Per vector: the word for device 0, 1, 2 in the order they are offered
  localparam logic [11:0] VEC [NVEC][NDEV] = '{
    '{12'hABC, 12'h123, 12'h456},
    '{12'hFFF, 12'h000, 12'hFFF},
    '{12'h800, 12'h001, 12'h7FE},
    '{12'h5A5, 12'hA5A, 12'h3C3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [11:0] inData = '0;
  logic inReady, busy, serClk, serData, frameSyncN, loadN;

  always #4 clk = ~clk;  // 125 MHz

  dac_chain_loader #(
    .NUM_DEV(NDEV), .DATA_W(12), .FRAME_W(16), .HALF_DIV(HALF), .LOAD_LEN(PLEN)
  ) u_dac_chain_loader (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .busy(busy), .serClk(serClk), .serData(serData), .frameSyncN(frameSyncN), .loadN(loadN)
  );

  // Behavioural device chain: sample on falling serial clock, latch on falling load
  logic [15:0] devSr  [NDEV] = '{default: 16'hFFFF};
  logic [11:0] devOut [NDEV] = '{default: 12'h000};
  logic [3:0]  devPad [NDEV] = '{default: 4'hF};

  always @(negedge serClk) begin
    if (!frameSyncN) begin
      for (int k = 0; k < NDEV; k++)
        devSr[k] <= {devSr[k][14:0], (k == 0) ? serData : devSr[k-1][15]};
    end
  end

  always @(negedge loadN) begin
    for (int k = 0; k < NDEV; k++) begin
      devOut[k] <= devSr[k][11:0];
      devPad[k] <= devSr[k][15:12];
    end
  end

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port monitor, sampled on the falling system clock
  int  fallCnt, lowRun, pulseRun, pulseFalls, badHalf, badSync, badBusy;
  logic prevSclk = 1'b1, prevLoad = 1'b1;

  task automatic clearMon();
    fallCnt = 0; pulseRun = 0; pulseFalls = 0; badHalf = 0; badSync = 0; badBusy = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (!frameSyncN && prevSclk && !serClk) fallCnt++;
      if (!serClk) lowRun++;
      else begin
        if (!prevSclk && lowRun != HALF) badHalf++;
        lowRun = 0;
      end
      if (prevLoad && !loadN) begin
        pulseFalls++;
        if (!frameSyncN) badSync++;
      end
      if (!loadN) begin
        pulseRun++;
        if (!busy) badBusy++;
      end
      prevSclk = serClk;
      prevLoad = loadN;
    end else begin
      lowRun = 0; prevSclk = 1'b1; prevLoad = 1'b1;
    end
  end

  // Watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic offerWord(input logic [11:0] w, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    inValid = 1'b1;
    inData  = w;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic checkTransfer(input logic [11:0] w0, input logic [11:0] w1, input logic [11:0] w2, input string tag);
    logic [11:0] exp [NDEV];
    exp[0] = w0; exp[1] = w1; exp[2] = w2;
    for (int k = 0; k < NDEV; k++) begin
      check(devOut[k] == exp[k], {"R5 device word ", tag}, devOut[k], exp[k]);
      check(devPad[k] == 4'h0, {"R4 padding zero ", tag}, devPad[k], 0);
    end
    check(fallCnt == BURST, {"R3 falls per burst ", tag}, fallCnt, BURST);
    check(pulseFalls == 1, {"R8 one load pulse ", tag}, pulseFalls, 1);
    check(pulseRun == PLEN, {"R8 load pulse width ", tag}, pulseRun, PLEN);
    check(badSync == 0, {"R7 load inside frame ", tag}, badSync, 0);
    check(badHalf == 0, {"R10 low phase width ", tag}, badHalf, 0);
    check(badBusy == 0, {"R9 busy during load ", tag}, badBusy, 0);
    check(serClk && frameSyncN && loadN && !busy, {"R10 idle levels ", tag},
          {serClk, frameSyncN, loadN, busy}, 4'b1110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(frameSyncN && loadN && serClk && !busy && inReady, "R1 in reset",
          {frameSyncN, loadN, serClk, busy, inReady}, 5'b11101);
    rstN = 1'b1;
    @(negedge clk);
    check(frameSyncN && loadN && serClk && !busy && inReady, "R1 after reset",
          {frameSyncN, loadN, serClk, busy, inReady}, 5'b11101);

    // Vector table walk
    for (int t = 0; t < NVEC; t++) begin
      clearMon();
      for (int k = 0; k < NDEV; k++) offerWord(VEC[t][k], t % 2);
      check(busy && !inReady, "R9 busy after last word", {busy, inReady}, 2'b10);
      if (t == 1) begin
        inValid = 1'b1; inData = 12'h3C3;
        repeat (20) @(negedge clk);
        check(!inReady, "R2 not ready while busy", inReady, 0);
        inValid = 1'b0;
      end
      waitIdle();
      @(negedge clk);
      checkTransfer(VEC[t][0], VEC[t][1], VEC[t][2], $sformatf("vec%0d", t));
    end

    // Partial set: no burst until all words are present
    clearMon();
    offerWord(12'h111, 0);
    repeat (10) @(negedge clk);
    check(!busy && frameSyncN && inReady, "R2 partial set idle", {busy, frameSyncN, inReady}, 3'b011);
    offerWord(12'h222, 3);
    offerWord(12'h333, 0);
    waitIdle();
    @(negedge clk);
    checkTransfer(12'h111, 12'h222, 12'h333, "partial");

    // Reset in the middle of a burst
    offerWord(12'hDEA, 0); offerWord(12'hBEE, 0); offerWord(12'hF00, 0);
    repeat (30) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(frameSyncN && loadN && serClk && !busy && inReady, "R1 reset mid burst",
          {frameSyncN, loadN, serClk, busy, inReady}, 5'b11101);
    rstN = 1'b1;
    @(negedge clk);
    clearMon();
    offerWord(12'h0F0, 0); offerWord(12'hF0F, 0); offerWord(12'h999, 0);
    waitIdle();
    @(negedge clk);
    checkTransfer(12'h0F0, 12'hF0F, 12'h999, "after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule